// File: doc/BRIEF.md
# Precision-time event frame timestamp unit

This block sits beside an Ethernet receive or transmit path and watches the frame stream, packed into big-endian 32-bit words (the first byte of a word is in bits 31:24). When a word flagged as frame start is accepted, the current real-time clock value (48-bit seconds, 32-bit nanoseconds) is captured. The header walker then follows the frame's header stack word by word to find a precision-time-protocol event message. The stack may hold VLAN tags, a stack of MPLS labels, and IPv4 or IPv6 with UDP. If it finds one, it pushes a 128-bit record into a 15-entry queue. The record holds the captured time, the message type, a 12-bit check field and the sequence identifier. A processor drains the queue through a valid/ready read port.

The input stream has no back-pressure. The walker accepts a word on every cycle in which `in_valid` is high, so the usual pacing of one word every four clocks is supported, and so is any faster pacing. On the record port, `rec_valid` stays high while the queue holds a record. `rec_data` shows the oldest record and does not change until a cycle with `rec_valid && rec_ready` pops it. When the queue is full, new records are discarded and a sticky flag is raised.

Top module: `ptp_ts_unit`

## Requirements
- R1: After reset, `rec_valid` and `overflow` are 0.
- R2: A frame whose type field (bytes 12-13) is 0x88F7 is raw PTP. The PTP header begins at byte 14. Its message type is the low nibble of PTP byte 0 and its sequence identifier is PTP bytes 30-31. The check field of the record is zero.
- R3: Up to two 0x8100 VLAN tags (4 bytes each, next type field follows the tag) are skipped. A frame with a third tag gives no record.
- R4: Type 0x0800 with IPv4 byte 0 equal to 0x45, protocol byte 9 equal to 17 and UDP destination port 319 is accepted. The PTP header follows the 8-byte UDP header, and the check field is the low 12 bits of the UDP checksum.
- R5: Type 0x86DD with IPv6 version 6 and next-header byte 6 equal to 17, followed by UDP to port 319, is accepted. The check field is formed as in R4.
- R6: After type 0x8847, 4-byte MPLS labels are skipped until one has its bottom-of-stack bit (bit 0 of the label's third byte) set. The version nibble of the next byte selects IPv4 (4) or IPv6 (6). At most 4 labels are allowed, and a fifth gives no record.
- R7: Only message types 0 to 3 make a record. Other message types, another UDP port or protocol, an unknown type field, or a frame that ends before its sequence identifier give no record.
- R8: The record time equals the clock inputs sampled in the cycle that accepts the start-of-frame word.
- R9: The record is, MSB to LSB: 16 zero bits, seconds[47:0], nanoseconds[31:0], message type[3:0], check field[11:0], sequence identifier[15:0].
- R10: The queue is first-in first-out. `rec_data` and `rec_valid` hold steady while `rec_valid && !rec_ready`.
- R11: A record that arrives while 15 records are queued is dropped, and `overflow` rises and stays 1 until reset.
- R12: With an empty queue, `rec_valid` rises on the second rising edge after the edge that accepts the word holding the sequence identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_sec | input | 48 | Real-time clock seconds |
| rtc_ns | input | 32 | Real-time clock nanoseconds |
| in_valid | input | 1 | Frame word present |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_data | input | 32 | Frame word, first byte in bits 31:24 |
| rec_valid | output | 1 | Queue holds a record |
| rec_ready | input | 1 | Consumer takes the shown record |
| rec_data | output | 128 | Oldest record |
| overflow | output | 1 | Sticky record-dropped flag |

## Verification
A record becomes visible two edges after its sequence word is accepted: one edge registers the walker's hit and the next writes the queue. The latency frame ends on its sequence word, and the bench samples `rec_valid` at the falling edge after each of those two edges, expecting 0 and then 1. All other checks come after the frame has been sent plus two idle clocks, so every expected record has settled. Pops happen by raising `rec_ready` for exactly one rising edge, and the result is read at the following falling edge.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_MPLS = 16'h8847;
  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] ET_IPV6 = 16'h86DD;
  localparam logic [15:0] ET_PTP  = 16'h88F7;
  localparam logic [15:0] UDP_EVENT_PORT = 16'd319;
  localparam logic [7:0]  PROTO_UDP      = 8'd17;

  // word offsets; header payload starts in the low half of anchor word
  localparam int FIRST_TYPE_WORD = 3;
  localparam int V4_PROTO_OFS = 2;
  localparam int V4_PORT_OFS  = 6;
  localparam int V4_PTP_OFS   = 7;
  localparam int V6_NXT_OFS   = 2;
  localparam int V6_PORT_OFS  = 11;
  localparam int V6_PTP_OFS   = 12;
  localparam int SEQ_OFS      = 8;

  localparam int REC_W = 128;

  typedef enum logic [2:0] {
    WK_IDLE, WK_TYPE, WK_MPLS, WK_IP4, WK_IP6, WK_PTP
  } walk_state_t;

  function automatic logic [REC_W-1:0] make_record(
      input logic [47:0] sec, input logic [31:0] ns,
      input logic [3:0] mtype, input logic [11:0] chk,
      input logic [15:0] seq);
    return {16'h0000, sec, ns, mtype, chk, seq};
  endfunction

endpackage

// File: rtl/ptp_hdr_walker.sv
module ptp_hdr_walker
  import ptp_ts_pkg::*;
#(
  parameter int MAX_VLAN   = 2,
  parameter int MAX_LABELS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [31:0] in_data,
  output logic        hit,
  output logic [3:0]  f_mtype,
  output logic [11:0] f_chk,
  output logic [15:0] f_seq
);

  localparam int MAX_WORD = FIRST_TYPE_WORD + MAX_VLAN + MAX_LABELS + V6_PTP_OFS + SEQ_OFS + 2;
  localparam int CNT_W    = $clog2(MAX_WORD + 1) + 1;
  localparam int VL_W     = $clog2(MAX_VLAN + 1);
  localparam int LB_W     = $clog2(MAX_LABELS + 1);

  walk_state_t      st;
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] anchor;
  logic [CNT_W-1:0] ptp_w;
  logic [VL_W-1:0]  n_vlan;
  logic [LB_W-1:0]  n_lab;

  logic [15:0] hi_half;
  logic        v4_start, v6_start, is_event;

  assign hi_half  = in_data[31:16];
  assign v4_start = (in_data[15:8] == 8'h45);
  assign v6_start = (in_data[15:12] == 4'h6);
  assign is_event = (in_data[11:10] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WK_IDLE;
      wcnt    <= '0;
      anchor  <= '0;
      ptp_w   <= '0;
      n_vlan  <= '0;
      n_lab   <= '0;
      hit     <= 1'b0;
      f_mtype <= '0;
      f_chk   <= '0;
      f_seq   <= '0;
    end else begin
      hit <= 1'b0;
      if (in_valid) begin
        if (in_sof) begin
          st     <= WK_TYPE;
          wcnt   <= CNT_W'(1);
          anchor <= CNT_W'(FIRST_TYPE_WORD);
          n_vlan <= '0;
          n_lab  <= '0;
        end else begin
          if (wcnt != '1) wcnt <= wcnt + CNT_W'(1);
          case (st)
            WK_TYPE: if (wcnt == anchor) begin
              case (hi_half)
                ET_VLAN: begin
                  if (n_vlan < VL_W'(MAX_VLAN)) begin
                    anchor <= anchor + CNT_W'(1);
                    n_vlan <= n_vlan + VL_W'(1);
                  end else st <= WK_IDLE;
                end
                ET_PTP: begin
                  f_mtype <= in_data[11:8];
                  f_chk   <= '0;
                  ptp_w   <= anchor;
                  st      <= is_event ? WK_PTP : WK_IDLE;
                end
                ET_IPV4: st <= v4_start ? WK_IP4 : WK_IDLE;
                ET_IPV6: st <= v6_start ? WK_IP6 : WK_IDLE;
                ET_MPLS: st <= WK_MPLS;
                default: st <= WK_IDLE;
              endcase
            end
            WK_MPLS: if (wcnt == anchor + CNT_W'(1)) begin
              anchor <= anchor + CNT_W'(1);
              if (in_data[24]) begin
                st <= v4_start ? WK_IP4 : (v6_start ? WK_IP6 : WK_IDLE);
              end else if (n_lab == LB_W'(MAX_LABELS - 1)) begin
                st <= WK_IDLE;
              end else begin
                n_lab <= n_lab + LB_W'(1);
              end
            end
            WK_IP4: begin
              if (wcnt == anchor + CNT_W'(V4_PROTO_OFS) && in_data[7:0] != PROTO_UDP)
                st <= WK_IDLE;
              if (wcnt == anchor + CNT_W'(V4_PORT_OFS) && hi_half != UDP_EVENT_PORT)
                st <= WK_IDLE;
              if (wcnt == anchor + CNT_W'(V4_PTP_OFS)) begin
                f_chk   <= in_data[27:16];
                f_mtype <= in_data[11:8];
                ptp_w   <= anchor + CNT_W'(V4_PTP_OFS);
                st      <= is_event ? WK_PTP : WK_IDLE;
              end
            end
            WK_IP6: begin
              if (wcnt == anchor + CNT_W'(V6_NXT_OFS) && in_data[31:24] != PROTO_UDP)
                st <= WK_IDLE;
              if (wcnt == anchor + CNT_W'(V6_PORT_OFS) && hi_half != UDP_EVENT_PORT)
                st <= WK_IDLE;
              if (wcnt == anchor + CNT_W'(V6_PTP_OFS)) begin
                f_chk   <= in_data[27:16];
                f_mtype <= in_data[11:8];
                ptp_w   <= anchor + CNT_W'(V6_PTP_OFS);
                st      <= is_event ? WK_PTP : WK_IDLE;
              end
            end
            WK_PTP: if (wcnt == ptp_w + CNT_W'(SEQ_OFS)) begin
              f_seq <= hi_half;
              hit   <= 1'b1;
              st    <= WK_IDLE;
            end
            default: st <= WK_IDLE;
          endcase
          if (in_eof) st <= WK_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/ptp_rec_fifo.sv
module ptp_rec_fifo #(
  parameter int DEPTH = 15,
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0]    count;
  logic             do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_nxt;
      if (do_rd) rd_ptr <= rd_nxt;
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ptp_ts_unit.sv
module ptp_ts_unit
  import ptp_ts_pkg::*;
#(
  parameter int MAX_VLAN   = 2,
  parameter int MAX_LABELS = 4,
  parameter int Q_DEPTH    = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [47:0]  rtc_sec,
  input  logic [31:0]  rtc_ns,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic         in_eof,
  input  logic [31:0]  in_data,
  output logic         rec_valid,
  input  logic         rec_ready,
  output logic [127:0] rec_data,
  output logic         overflow
);

  logic [47:0] ts_sec;
  logic [31:0] ts_ns;
  logic        hit;
  logic [3:0]  f_mtype;
  logic [11:0] f_chk;
  logic [15:0] f_seq;
  logic        q_empty, q_full;
  logic [REC_W-1:0] new_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_sec <= '0;
      ts_ns  <= '0;
    end else if (in_valid && in_sof) begin
      ts_sec <= rtc_sec;
      ts_ns  <= rtc_ns;
    end
  end

  ptp_hdr_walker #(
    .MAX_VLAN  (MAX_VLAN),
    .MAX_LABELS(MAX_LABELS)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sof  (in_sof),
    .in_eof  (in_eof),
    .in_data (in_data),
    .hit     (hit),
    .f_mtype (f_mtype),
    .f_chk   (f_chk),
    .f_seq   (f_seq)
  );

  assign new_rec = make_record(ts_sec, ts_ns, f_mtype, f_chk, f_seq);

  ptp_rec_fifo #(
    .DEPTH(Q_DEPTH),
    .WIDTH(REC_W)
  ) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (hit),
    .wr_data(new_rec),
    .rd_en  (rec_ready),
    .rd_data(rec_data),
    .empty  (q_empty),
    .full   (q_full)
  );

  assign rec_valid = !q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else if (hit && q_full) overflow <= 1'b1;
  end

endmodule

// File: rtl/ptp_ts_unit_chk.sv
module ptp_ts_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         rec_valid,
  input logic         rec_ready,
  input logic [127:0] rec_data,
  input logic         overflow
);

  // R10
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));

  // R10
  drop_needs_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_valid) |-> $past(rec_ready));

  // R11
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R11
  ovf_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(rec_valid));

  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_data[127:112] == 16'h0000);

endmodule

bind ptp_ts_unit ptp_ts_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rec_valid(rec_valid),
  .rec_ready(rec_ready),
  .rec_data (rec_data),
  .overflow (overflow)
);

// File: tb/test_ptp_ts_unit.sv
module test_ptp_ts_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [47:0]  rtc_sec = '0;
  logic [31:0]  rtc_ns = '0;
  logic         in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0]  in_data = '0;
  logic         rec_valid, rec_ready = 1'b0, overflow;
  logic [127:0] rec_data;

  int n_chk = 0, n_err = 0;
  logic [7:0] fb [0:255];
  int fl;
  int g_proto = 17, g_port = 319, g_et = -1, g_trunc = 0;
  int fid = 0;

  always #10 clk = ~clk;

  ptp_ts_unit i_ptp_ts_unit (
    .clk(clk), .rst_n(rst_n), .rtc_sec(rtc_sec), .rtc_ns(rtc_ns),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .overflow(overflow)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put8(input logic [7:0] b);
    fb[fl] = b;
    fl++;
  endtask

  task automatic put16(input logic [15:0] h);
    put8(h[15:8]);
    put8(h[7:0]);
  endtask

  // kind: 0 raw, 1 IPv4/UDP, 2 IPv6/UDP
  task automatic build(input int kind, input int nvl, input int nlab,
                       input logic [3:0] mt, input logic [15:0] seq, input logic [15:0] cks);
    fl = 0;
    for (int i = 0; i < 12; i++) put8(8'(i * 7 + 1));
    for (int i = 0; i < nvl; i++) begin put16(16'h8100); put16(16'(16'h0005 + i)); end
    if (nlab > 0) begin
      put16(16'h8847);
      for (int i = 0; i < nlab; i++) begin
        logic [19:0] lb;
        lb = 20'(20'h12345 + i);
        put8(lb[19:12]); put8(lb[11:4]);
        put8({lb[3:0], 3'b000, (i == nlab - 1) ? 1'b1 : 1'b0});
        put8(8'd64);
      end
    end else if (g_et >= 0) put16(16'(g_et));
    else put16(kind == 0 ? 16'h88F7 : (kind == 1 ? 16'h0800 : 16'h86DD));
    if (kind == 1) begin
      put8(8'h45); put8(8'h00); put16(16'd72); put16(16'h0); put16(16'h0);
      put8(8'd64); put8(8'(g_proto)); put16(16'h0);
      for (int i = 0; i < 8; i++) put8(8'(8'h10 + i));
    end else if (kind == 2) begin
      put8(8'h60); put8(8'h00); put16(16'h0); put16(16'd52);
      put8(8'(g_proto)); put8(8'd64);
      for (int i = 0; i < 32; i++) put8(8'(8'h30 + i));
    end
    if (kind != 0) begin
      put16(16'd319); put16(16'(g_port)); put16(16'd52); put16(cks);
    end
    put8({4'h0, mt}); put8(8'h02);
    for (int i = 0; i < 28; i++) put8(8'(8'hA0 + i));
    put16(seq);
    for (int i = 0; i < 12; i++) put8(8'h00);
    if (g_trunc > 0) fl = g_trunc;
  endtask

  task automatic send(input logic [47:0] sec, input logic [31:0] ns, input bit lat);
    int nw;
    nw = (fl + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (w == 0);
      in_eof = (w == nw - 1);
      for (int b = 0; b < 4; b++)
        in_data[31 - 8*b -: 8] = (4*w + b < fl) ? fb[4*w + b] : 8'h00;
      if (w == 0) begin rtc_sec = sec; rtc_ns = ns; end
      else begin rtc_sec = ~sec; rtc_ns = ~ns; end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      if (lat && w == nw - 1) begin
        chk(rec_valid == 1'b0, "R12 one edge after sequence word", 128'(rec_valid), 128'd0);
        @(negedge clk);
        chk(rec_valid == 1'b1, "R12 two edges after sequence word", 128'(rec_valid), 128'd1);
      end else repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [127:0] exp_rec(input int kind, input logic [3:0] mt,
      input logic [15:0] seq, input logic [15:0] cks, input logic [47:0] sec, input logic [31:0] ns);
    return {16'h0, sec, ns, mt, (kind == 0) ? 12'h000 : cks[11:0], seq};
  endfunction

  task automatic pop_check(input logic [127:0] exp, input string tag);
    @(negedge clk);
    chk(rec_valid == 1'b1, tag, 128'(rec_valid), 128'd1);
    chk(rec_data == exp, tag, rec_data, exp);
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
  endtask

  // one positive frame: build, send, check record
  task automatic good_frame(input int kind, input int nvl, input int nlab,
                            input logic [3:0] mt, input string tag);
    logic [47:0] s; logic [31:0] n; logic [15:0] sq, ck;
    fid++;
    s = 48'h0100_0000_0000 + 48'(fid); n = 32'(fid * 1000 + 7);
    sq = 16'(16'h4000 + fid * 3); ck = 16'(16'hB000 + fid * 17);
    build(kind, nvl, nlab, mt, sq, ck);
    send(s, n, 1'b0);
    pop_check(exp_rec(kind, mt, sq, ck, s, n), tag);
  endtask

  task automatic bad_frame(input int kind, input int nvl, input int nlab,
                           input logic [3:0] mt, input string tag);
    fid++;
    build(kind, nvl, nlab, mt, 16'h1111, 16'h2222);
    send(48'(fid), 32'(fid), 1'b0);
    @(negedge clk);
    chk(rec_valid == 1'b0, tag, 128'(rec_valid), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rec_valid == 1'b0, "R1 rec_valid after reset", 128'(rec_valid), 128'd0);
    chk(overflow == 1'b0, "R1 overflow after reset", 128'(overflow), 128'd0);

    // sweep encapsulations, tag counts and event types (R2 R3 R4 R5 R8 R9)
    for (int k = 0; k < 3; k++)
      for (int v = 0; v < 3; v++)
        for (int m = 0; m < 4; m++)
          good_frame(k, v, 0, 4'(m), k == 0 ? "R2/R3/R8/R9 raw" :
                     (k == 1 ? "R4/R3/R8/R9 ipv4" : "R5/R3/R8/R9 ipv6"));

    // MPLS stacks of 1..4 labels (R6)
    for (int k = 1; k < 3; k++)
      for (int l = 1; l < 5; l++)
        good_frame(k, l % 2, l, 4'(l - 1), "R6 mpls stack");

    // rejects (R7 R3 R6)
    for (int m = 4; m < 16; m++) bad_frame(0, 0, 0, 4'(m), "R7 general message type");
    bad_frame(1, 0, 0, 4'd4, "R7 ipv4 general type");
    g_port = 320; bad_frame(1, 0, 0, 4'd0, "R7 ipv4 wrong port");
    bad_frame(2, 1, 0, 4'd1, "R7 ipv6 wrong port"); g_port = 319;
    g_proto = 6; bad_frame(1, 0, 0, 4'd0, "R7 ipv4 not udp");
    bad_frame(2, 0, 0, 4'd0, "R7 ipv6 not udp"); g_proto = 17;
    g_et = 16'h0806; bad_frame(0, 0, 0, 4'd0, "R7 unknown type field"); g_et = -1;
    g_trunc = 44; bad_frame(0, 0, 0, 4'd0, "R7 frame ends early"); g_trunc = 0;
    bad_frame(0, 3, 0, 4'd0, "R3 third vlan tag");
    bad_frame(1, 0, 5, 4'd0, "R6 fifth mpls label");

    // latency: frame ends on the sequence word (R12)
    g_trunc = 48;
    build(0, 0, 0, 4'd3, 16'hCAFE, 16'h0);
    send(48'h7, 32'h9, 1'b1);
    g_trunc = 0;
    pop_check(exp_rec(0, 4'd3, 16'hCAFE, 16'h0, 48'h7, 32'h9), "R12 record content");

    // fill, overflow, hold, order (R10 R11)
    for (int i = 0; i < 17; i++) begin
      build(i % 3, 0, 0, 4'(i % 4), 16'(100 + i), 16'(16'h0F00 + i));
      send(48'(200 + i), 32'(300 + i), 1'b0);
    end
    @(negedge clk);
    chk(overflow == 1'b1, "R11 overflow after drop", 128'(overflow), 128'd1);
    held = rec_data;
    repeat (5) @(negedge clk);
    chk(rec_data == held && rec_valid, "R10 record held without ready", rec_data, held);
    for (int i = 0; i < 15; i++)
      pop_check(exp_rec(i % 3, 4'(i % 4), 16'(100 + i), 16'(16'h0F00 + i),
                        48'(200 + i), 32'(300 + i)), "R10 fifo order");
    @(negedge clk);
    chk(rec_valid == 1'b0, "R11 dropped records absent", 128'(rec_valid), 128'd0);
    chk(overflow == 1'b1, "R11 overflow sticky", 128'(overflow), 128'd1);
    report();
  end

endmodule